// File: doc/BRIEF.md
# Fixed-Burst Write Downsizer into a Word FIFO

This block is the write side of a memory-mapped FIFO port. It is a write slave with a 64-bit data path that takes FIXED-type bursts. All beats of such a burst go to one address. Each data beat becomes 32-bit words pushed into an internal first-word-fall-through FIFO. A consumer drains the FIFO through a 32-bit valid/ready read port, and a full flag and an empty flag report the FIFO state. A repeated write to the same address always adds a new entry and never replaces an older one.

The beat size field selects how each beat is handled. An 8-byte beat is split into two pushes: the low word goes first, then the high word. A beat of 4 bytes or less makes one push, taken from the 32-bit lane that address bit 2 selects. That lane is captured once per burst. An unsupported burst type or beat size is still accepted and drained, but it pushes nothing and ends with an error response. Data-channel backpressure appears whenever the next push cannot happen.

The controller has four states. `ST_ADDR` waits for an address. `ST_DATA` takes data beats. `ST_UPPER` pushes the held high word of a split beat. `ST_RESP` presents the write response. The transitions are as follows:
- ADDR→DATA on an address handshake.
- DATA→UPPER on a legal 8-byte beat.
- DATA→RESP on the closing beat of a burst that is not split, or of a rejected burst.
- UPPER→DATA once the high word is pushed and more beats follow.
- UPPER→RESP once the high word of the closing beat is pushed.
- RESP→ADDR on the response handshake.

Top module: `fxd_wr_downsizer`

## Requirements
- R1: With a beat size code of 3 (8 bytes) on a FIXED burst, each beat pushes two words: bits 31:0 first, then bits 63:32.
- R2: With a beat size code of 0, 1 or 2, each beat pushes exactly one word. The word is bits 31:0 when address bit 2 is 0 and bits 63:32 when it is 1. The lane is captured at the address handshake and used for every beat of the burst.
- R3: Every push creates a new FIFO entry, and entries leave the read port in beat order with no word lost or overwritten.
- R4: A burst has length field + 1 beats. The response is OKAY (2'b00) only when the last-beat flag is high on exactly that final beat. If the flag comes early, the burst ends at that beat with SLVERR (2'b10). If the flag is missing, the burst ends after the final beat with SLVERR.
- R5: The data-channel ready is low in the cycle after a split beat is taken, while its high word waits to be pushed. It is also low whenever the FIFO is full during a legal burst.
- R6: A burst type other than FIXED (2'b00), or a size code above 3, has its beats accepted without stalls. Such a burst pushes nothing and is answered with SLVERR.
- R7: Exactly one response follows each burst, and only after the last push. It stays valid with a stable code until the response ready is seen. The address ready stays low while the response is pending.
- R8: The FIFO holds 16 words. The read valid equals not-empty, the read data shows the oldest word without a request, and the full flag is set when 16 words are held.
- R9: After reset the address ready is high, the data ready and response valid are low, the empty flag is high and the full flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | 32 | Write address; bit 2 selects the lane for narrow beats |
| aw_len | input | 8 | Burst length minus one |
| aw_size | input | 3 | Beat size code; bytes = 2**code |
| aw_burst | input | 2 | Burst type; 2'b00 is FIXED |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 64 | Write data |
| w_last | input | 1 | Last beat of the burst |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | output | 2 | Response code, 2'b00 OKAY, 2'b10 SLVERR |
| rd_data | output | 32 | Oldest FIFO word |
| rd_valid | output | 1 | FIFO holds at least one word |
| rd_ready | input | 1 | Consumer takes the oldest word |
| fifo_full | output | 1 | FIFO holds 16 words |
| fifo_empty | output | 1 | FIFO holds no words |

## Verification
Suppose the controller leaves `ST_UPPER` too early or takes the wrong lane. The read port then delivers a wrong or missing word on the first pop of that burst, and the scoreboard catches it within a few cycles. If the beat counter or the last-beat comparison is wrong, the burst either hangs or returns the wrong code. The response code is checked as soon as response valid rises. A FIFO pointer or flag error shows at once as a read-valid word with nothing expected, or as a full flag and data stall that does not appear at the sixteenth word.

// File: rtl/fxd_pkg.sv
package fxd_pkg;
    typedef enum logic [1:0] {
        ST_ADDR,
        ST_DATA,
        ST_UPPER,
        ST_RESP
    } wr_state_t;

    localparam logic [1:0] BURST_FIXED = 2'b00;
    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [2:0] SIZE_WIDE   = 3'd3;
endpackage

// File: rtl/fxd_word_fifo.sv
module fxd_word_fifo #(
    parameter int DW    = 32,
    parameter int DEPTH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] pop_data,
    output logic          full,
    output logic          empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count, count_nxt;
    logic             full_q, empty_q;
    logic             do_push, do_pop;

    assign do_push   = push && !full_q;
    assign do_pop    = pop && !empty_q;
    assign count_nxt = count + CNT_W'(do_push) - CNT_W'(do_pop);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr  <= '0;
            rd_ptr  <= '0;
            count   <= '0;
            full_q  <= 1'b0;
            empty_q <= 1'b1;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count   <= count_nxt;
            full_q  <= (count_nxt == CNT_W'(DEPTH));
            empty_q <= (count_nxt == '0);
        end
    end

    assign pop_data = mem[rd_ptr];
    assign full     = full_q;
    assign empty    = empty_q;

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full_q);
    // R8
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty_q);
    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(full_q && empty_q));
    // R3
    empty_after_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && !do_pop) |=> !empty_q);
endmodule

// File: rtl/fxd_wr_ctrl.sv
module fxd_wr_ctrl
    import fxd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int AXI_DW = 64,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [1:0]        aw_burst,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [AXI_DW-1:0] w_data,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    output logic              push,
    output logic [WORD_W-1:0] push_data,
    input  logic              fifo_full
);
    localparam int LANES    = AXI_DW / WORD_W;
    localparam int LANE_W   = $clog2(LANES);
    localparam int LANE_LSB = $clog2(WORD_W / 8);

    wr_state_t         state, state_nxt;
    logic [LEN_W-1:0]  len_q, beat_q;
    logic [2:0]        size_q;
    logic [LANE_W-1:0] lane_q, lane_sel;
    logic              bad_q, perr_q, end_q;
    logic [WORD_W-1:0] hi_q;
    logic              aw_hs, w_hs, final_beat, beat_end, split;

    assign aw_hs      = aw_valid && aw_ready;
    assign w_hs       = w_valid && w_ready;
    assign final_beat = (beat_q == len_q);
    assign beat_end   = w_last || final_beat;
    assign split      = (size_q == SIZE_WIDE);
    assign lane_sel   = split ? '0 : lane_q;

    // State register and captured burst attributes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_ADDR;
            len_q  <= '0;
            beat_q <= '0;
            size_q <= '0;
            lane_q <= '0;
            bad_q  <= 1'b0;
            perr_q <= 1'b0;
            end_q  <= 1'b0;
            hi_q   <= '0;
        end else begin
            state <= state_nxt;
            if (aw_hs) begin
                len_q  <= aw_len;
                beat_q <= '0;
                size_q <= aw_size;
                lane_q <= aw_addr[LANE_LSB +: LANE_W];
                bad_q  <= (aw_burst != BURST_FIXED) || (aw_size > SIZE_WIDE);
                perr_q <= 1'b0;
            end
            if (state == ST_DATA && w_hs) begin
                beat_q <= beat_q + 1'b1;
                hi_q   <= w_data[AXI_DW-1 -: WORD_W];
                end_q  <= beat_end;
                if (w_last != final_beat) perr_q <= 1'b1;
            end
        end
    end

    // Outputs and next state
    always_comb begin
        state_nxt = state;
        aw_ready  = 1'b0;
        w_ready   = 1'b0;
        b_valid   = 1'b0;
        push      = 1'b0;
        push_data = w_data[lane_sel*WORD_W +: WORD_W];
        unique case (state)
            ST_ADDR: begin
                aw_ready = 1'b1;
                if (aw_valid) state_nxt = ST_DATA;
            end
            ST_DATA: begin
                w_ready = bad_q ? 1'b1 : !fifo_full;
                if (w_hs) begin
                    push = !bad_q;
                    if (!bad_q && split) state_nxt = ST_UPPER;
                    else if (beat_end)   state_nxt = ST_RESP;
                end
            end
            ST_UPPER: begin
                push_data = hi_q;
                push      = !fifo_full;
                if (!fifo_full) state_nxt = end_q ? ST_RESP : ST_DATA;
            end
            ST_RESP: begin
                b_valid = 1'b1;
                if (b_ready) state_nxt = ST_ADDR;
            end
            default: state_nxt = ST_ADDR;
        endcase
    end

    assign b_resp = (bad_q || perr_q) ? RESP_SLVERR : RESP_OKAY;

    // R7
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_resp)));
    // R7
    aw_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_valid |-> !aw_ready);
    // R5
    upper_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && push && split) |=> !w_ready);
    // R5
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && !bad_q) |-> !w_ready);
    // R6
    bad_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_q && state != ST_ADDR) |-> !push);
endmodule

// File: rtl/fxd_wr_downsizer.sv
module fxd_wr_downsizer #(
    parameter int ADDR_W = 32,
    parameter int AXI_DW = 64,
    parameter int WORD_W = 32,
    parameter int LEN_W  = 8,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              aw_valid,
    output logic              aw_ready,
    input  logic [ADDR_W-1:0] aw_addr,
    input  logic [LEN_W-1:0]  aw_len,
    input  logic [2:0]        aw_size,
    input  logic [1:0]        aw_burst,
    input  logic              w_valid,
    output logic              w_ready,
    input  logic [AXI_DW-1:0] w_data,
    input  logic              w_last,
    output logic              b_valid,
    input  logic              b_ready,
    output logic [1:0]        b_resp,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    input  logic              rd_ready,
    output logic              fifo_full,
    output logic              fifo_empty
);
    logic              push;
    logic [WORD_W-1:0] push_data;

    fxd_wr_ctrl #(
        .ADDR_W(ADDR_W), .AXI_DW(AXI_DW), .WORD_W(WORD_W), .LEN_W(LEN_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .push(push), .push_data(push_data), .fifo_full(fifo_full)
    );

    fxd_word_fifo #(
        .DW(WORD_W), .DEPTH(DEPTH)
    ) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(push_data),
        .pop(rd_valid && rd_ready), .pop_data(rd_data),
        .full(fifo_full), .empty(fifo_empty)
    );

    assign rd_valid = !fifo_empty;

    // R8
    rd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
endmodule

// File: tb/fxd_wr_downsizer_bench.sv
module fxd_wr_downsizer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        aw_valid = 1'b0, aw_ready;
    logic [31:0] aw_addr = '0;
    logic [7:0]  aw_len = '0;
    logic [2:0]  aw_size = '0;
    logic [1:0]  aw_burst = '0;
    logic        w_valid = 1'b0, w_ready, w_last = 1'b0;
    logic [63:0] w_data = '0;
    logic        b_valid, b_ready = 1'b0;
    logic [1:0]  b_resp;
    logic [31:0] rd_data;
    logic        rd_valid, rd_ready = 1'b0;
    logic        fifo_full, fifo_empty;

    int          n_chk = 0;
    int          n_fail = 0;
    bit          rd_en = 1'b1;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    fxd_wr_downsizer u_fxd_wr_downsizer (
        .clk(clk), .rst_n(rst_n),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
        .aw_len(aw_len), .aw_size(aw_size), .aw_burst(aw_burst),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_last(w_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [15:0] s, input int i);
        logic [7:0] b;
        b = i[7:0];
        return {s, 8'hC3, b, ~s, 8'h3C, b};
    endfunction

    // Monitor: pops the read port and compares with the scoreboard (R3, R8)
    initial begin
        forever begin
            @(negedge clk);
            if (rd_en && rd_valid && rst_n) begin
                rd_ready = 1'b1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3", "unexpected word", {32'h0, rd_data}, 64'h0);
                end else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(rd_data == e, "R3", "word order/value", {32'h0, rd_data}, {32'h0, e});
                end
            end else begin
                rd_ready = 1'b0;
            end
        end
    end

    // Driver: one burst, expected words go into the scoreboard
    task automatic run_burst(input logic [31:0] addr, input int len, input logic [2:0] size,
                             input logic [1:0] burst, input int last_at, input logic [15:0] seed,
                             input string req);
        bit legal;
        bit exp_err;
        logic [1:0] exp_resp;
        int t;
        legal    = (burst == 2'b00) && (size <= 3'd3);
        exp_err  = !legal || (last_at != len);
        exp_resp = exp_err ? 2'b10 : 2'b00;
        @(negedge clk);
        aw_addr = addr; aw_len = len[7:0]; aw_size = size; aw_burst = burst; aw_valid = 1'b1;
        while (!aw_ready) @(negedge clk);
        @(negedge clk);
        aw_valid = 1'b0;
        for (int i = 0; ; i++) begin
            logic [63:0] d;
            d = mk(seed, i);
            if (legal) begin
                if (size == 3'd3) begin
                    exp_q.push_back(d[31:0]);
                    exp_q.push_back(d[63:32]);
                end else begin
                    exp_q.push_back(addr[2] ? d[63:32] : d[31:0]);
                end
            end
            w_data = d; w_last = (i == last_at); w_valid = 1'b1;
            while (!w_ready) @(negedge clk);
            @(negedge clk);
            w_valid = 1'b0; w_last = 1'b0;
            if (legal && size == 3'd3)
                chk(!w_ready, "R5", "ready low while upper word pending", {63'h0, w_ready}, 64'h0);
            if (i == len || i == last_at) break;
        end
        t = 0;
        while (!b_valid && t < 500) begin @(negedge clk); t++; end
        chk(b_valid, req, "response appears", {63'h0, b_valid}, 64'h1);
        chk(b_resp == exp_resp, req, "response code", {62'h0, b_resp}, {62'h0, exp_resp});
        chk(!aw_ready, "R7", "no address accepted while response pending", {63'h0, aw_ready}, 64'h0);
        repeat (2) @(negedge clk);
        chk(b_valid && b_resp == exp_resp, "R7", "response held without ready",
            {61'h0, b_valid, b_resp}, {61'h0, 1'b1, exp_resp});
        b_ready = 1'b1;
        @(negedge clk);
        b_ready = 1'b0;
        chk(!b_valid && aw_ready, "R7", "single response then address ready",
            {62'h0, b_valid, aw_ready}, 64'h1);
    endtask

    task automatic drain(input string req);
        int t;
        t = 0;
        while ((exp_q.size() != 0 || !fifo_empty) && t < 2000) begin @(negedge clk); t++; end
        chk(exp_q.size() == 0, req, "scoreboard drained", 64'(exp_q.size()), 64'h0);
        chk(fifo_empty, req, "fifo empty after drain", {63'h0, fifo_empty}, 64'h1);
    endtask

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(aw_ready, "R9", "aw_ready after reset", {63'h0, aw_ready}, 64'h1);
        chk(!w_ready && !b_valid, "R9", "w_ready/b_valid after reset",
            {62'h0, w_ready, b_valid}, 64'h0);
        chk(fifo_empty && !fifo_full && !rd_valid, "R9", "flags after reset",
            {61'h0, fifo_empty, fifo_full, rd_valid}, 64'h4);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: 8-byte beats split low then high
        run_burst(32'h1000, 3, 3'd3, 2'b00, 3, 16'h1111, "R1");
        // R2: 4-byte beats, upper lane by address bit 2
        run_burst(32'h1004, 4, 3'd2, 2'b00, 4, 16'h2222, "R2");
        // R2: 4-byte single beat, lower lane
        run_burst(32'h1000, 0, 3'd2, 2'b00, 0, 16'h3333, "R2");
        // R2: 2-byte beats still one push each, upper lane
        run_burst(32'h2004, 1, 3'd1, 2'b00, 1, 16'h4444, "R2");
        drain("R3");
        // R4: early last flag
        run_burst(32'h1000, 5, 3'd3, 2'b00, 1, 16'h5555, "R4");
        // R4: missing last flag
        run_burst(32'h1000, 1, 3'd2, 2'b00, -1, 16'h6666, "R4");
        drain("R4");
        // R6: INCR burst type is drained without pushes
        run_burst(32'h1000, 2, 3'd3, 2'b01, 2, 16'h7777, "R6");
        repeat (3) @(negedge clk);
        chk(fifo_empty, "R6", "no push from INCR burst", {63'h0, fifo_empty}, 64'h1);
        // R6: oversize beat code
        run_burst(32'h1000, 1, 3'd4, 2'b00, 1, 16'h8888, "R6");
        repeat (3) @(negedge clk);
        chk(fifo_empty, "R6", "no push from oversize beat", {63'h0, fifo_empty}, 64'h1);

        // R5/R8: fill the 16-word FIFO with the consumer stopped
        rd_en = 1'b0;
        fork
            run_burst(32'h3000, 19, 3'd2, 2'b00, 19, 16'h9999, "R8");
            begin
                repeat (40) @(negedge clk);
                chk(fifo_full, "R8", "full at 16 words", {63'h0, fifo_full}, 64'h1);
                chk(!w_ready, "R5", "ready low while full", {63'h0, w_ready}, 64'h0);
                chk(!b_valid, "R7", "no response before last push", {63'h0, b_valid}, 64'h0);
                chk(rd_valid && rd_data == mk(16'h9999, 0)[31:0], "R8", "oldest word shown",
                    {31'h0, rd_valid, rd_data}, {31'h0, 1'b1, mk(16'h9999, 0)[31:0]});
                rd_en = 1'b1;
            end
        join
        drain("R8");
        finish_run();
    end
endmodule